// File: doc/BRIEF.md
# Mapped-Branch Microprogram Sequencer

The block holds a microprogram address register and a 256-word control store whose contents are fixed at elaboration through a parameter. On every clock edge where stepping is allowed, the register loads a new address. That address comes from one of two places. One is the 8-bit link field of the word now being executed. The other is the external 4-bit opcode with four zero bits placed after it, so each opcode lands on the start of its own 16-word slot. A single select bit in the word picks between the two.

The upper field of the current word drives the datapath controls. Its width is the word width minus nine. A control unit dispatches on an instruction opcode by placing a word with the select bit set at the end of its fetch routine. Every other step either follows its link field or, with stepping held off, waits in place.

Top module: `ucode_sequencer`

## Requirements
- R1: `uop_o` equals bits WORD_W-1 down to 9 of the control-store word at the current address, and is WORD_W-9 bits wide. It follows an address change in the same cycle, with no extra register.
- R2: On an edge with `en_i` high, `clr_i` low and bit 8 of the current word at 0, the address loads bits 7:0 of that word. `opcode_i` has no effect in this case.
- R3: On an edge with `en_i` high, `clr_i` low and bit 8 of the current word at 1, the address loads `{opcode_i, 4'b0000}`.
- R4: With `clr_i` high and `en_i` high, the address becomes 0 on the next clock edge.
- R5: `clr_i` outranks `en_i`. With `clr_i` high and `en_i` low, the address still becomes 0 on the edge.
- R6: With `en_i` low and `clr_i` low, the address and `uop_o` keep their values across the edge.
- R7: Driving `rst_ni` low forces the address to 0 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| en_i | input | 1 | Allows the address to step |
| clr_i | input | 1 | Synchronous clear of the address to 0 |
| opcode_i | input | 4 | Opcode used for mapped branches |
| uop_o | output | WORD_W-9 | Micro-operation field of the current word |

## Verification
The bench builds the block with WORD_W at 20, which gives an 11-bit micro-operation field. It loads a computed control store in which each word's micro-operation field carries its own address in the low eight bits and a scrambled copy of that address in the top three. This makes the address register visible at the port on every cycle. Roughly one word in five has the select bit set, and the link fields are scattered across the store. Random opcodes, enable and clear therefore reach mapped dispatch, linked steps, holds and clears both with and without enable.

// File: rtl/ucode_seq_pkg.sv
package ucode_seq_pkg;
  typedef enum logic [1:0] {
    STEP_HOLD  = 2'd0,
    STEP_LINK  = 2'd1,
    STEP_MAP   = 2'd2,
    STEP_CLEAR = 2'd3
  } step_e;

  function automatic step_e pick_step(input logic en, input logic clr, input logic map_sel);
    if (clr)          return STEP_CLEAR;
    else if (!en)     return STEP_HOLD;
    else if (map_sel) return STEP_MAP;
    else              return STEP_LINK;
  endfunction
endpackage

// File: rtl/useq_rom.sv
module useq_rom #(
  parameter int WORD_W = 20,
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 1 << ADDR_W,
  parameter logic [DEPTH*WORD_W-1:0] IMAGE = '0
) (
  input  logic [ADDR_W-1:0] addr_i,
  output logic [WORD_W-1:0] word_o
);
  always_comb word_o = IMAGE[addr_i*WORD_W +: WORD_W];
endmodule

// File: rtl/useq_next.sv
module useq_next
  import ucode_seq_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int ADDR_W = 8,
  parameter int OPC_W  = 4
) (
  input  logic [WORD_W-1:0] word_i,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic              en_i,
  input  logic              clr_i,
  output step_e             step_o,
  output logic [ADDR_W-1:0] target_o
);
  localparam int PAD_W = ADDR_W - OPC_W;

  logic              map_sel;
  logic [ADDR_W-1:0] link_addr;
  logic [ADDR_W-1:0] map_addr;

  assign map_sel   = word_i[ADDR_W];
  assign link_addr = word_i[ADDR_W-1:0];
  assign map_addr  = {opcode_i, {PAD_W{1'b0}}};

  always_comb begin
    step_o = pick_step(en_i, clr_i, map_sel);
    unique case (step_o)
      STEP_MAP:  target_o = map_addr;
      STEP_LINK: target_o = link_addr;
      default:   target_o = '0;
    endcase
  end
endmodule

// File: rtl/useq_pc.sv
module useq_pc
  import ucode_seq_pkg::*;
#(
  parameter int ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  step_e             step_i,
  input  logic [ADDR_W-1:0] target_i,
  output logic [ADDR_W-1:0] addr_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 addr_o <= '0;
    else if (step_i != STEP_HOLD) addr_o <= target_i;
  end
endmodule

// File: rtl/ucode_sequencer.sv
module ucode_sequencer
  import ucode_seq_pkg::*;
#(
  parameter int WORD_W = 20,
  parameter int ADDR_W = 8,
  parameter int OPC_W  = 4,
  parameter int DEPTH  = 1 << ADDR_W,
  parameter int UOP_W  = WORD_W - ADDR_W - 1,
  parameter logic [DEPTH*WORD_W-1:0] IMAGE = '0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             clr_i,
  input  logic [OPC_W-1:0] opcode_i,
  output logic [UOP_W-1:0] uop_o
);
  logic [ADDR_W-1:0] upc_q;
  logic [ADDR_W-1:0] target;
  logic [WORD_W-1:0] cur_word;
  step_e             step;

  useq_rom #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH), .IMAGE(IMAGE)) u_rom (
    .addr_i(upc_q),
    .word_o(cur_word)
  );

  useq_next #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_next (
    .word_i  (cur_word),
    .opcode_i(opcode_i),
    .en_i    (en_i),
    .clr_i   (clr_i),
    .step_o  (step),
    .target_o(target)
  );

  useq_pc #(.ADDR_W(ADDR_W)) u_pc (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .step_i  (step),
    .target_i(target),
    .addr_o  (upc_q)
  );

  assign uop_o = cur_word[WORD_W-1:ADDR_W+1];
endmodule

// File: rtl/ucode_sequencer_chk.sv
module ucode_sequencer_chk #(
  parameter int WORD_W = 20,
  parameter int ADDR_W = 8,
  parameter int OPC_W  = 4
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              en_i,
  input logic              clr_i,
  input logic [OPC_W-1:0]  opcode_i,
  input logic [ADDR_W-1:0] addr,
  input logic [WORD_W-1:0] word
);
  a_r2_link_follow: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && !word[ADDR_W]) |=> addr == $past(word[ADDR_W-1:0]));

  a_r3_map_dispatch: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !clr_i && word[ADDR_W]) |=> addr == {$past(opcode_i), {(ADDR_W-OPC_W){1'b0}}});

  a_r4_clear_zero: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && en_i) |=> addr == '0);

  a_r5_clear_over_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clr_i && !en_i) |=> addr == '0);

  a_r6_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !clr_i) |=> $stable(addr));
endmodule

bind ucode_sequencer ucode_sequencer_chk #(.WORD_W(WORD_W), .ADDR_W(ADDR_W), .OPC_W(OPC_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .clr_i   (clr_i),
  .opcode_i(opcode_i),
  .addr    (upc_q),
  .word    (cur_word)
);

// File: tb/ucode_sequencer_test.sv
`timescale 1ns/1ps
module ucode_sequencer_test;
  localparam int W = 20;
  localparam int N = 256;

  function automatic logic [N*W-1:0] build_img();
    logic [N*W-1:0] img;
    img = '0;
    for (int a = 0; a < N; a++) begin
      logic [7:0] ad;
      logic [7:0] nx;
      logic       mp;
      ad = 8'(a);
      nx = 8'((a * 37 + 11) % 256);
      mp = (a % 5) == 0;
      img[a*W +: W] = {ad[2:0] ^ 3'b101, ad, mp, nx};
    end
    return img;
  endfunction

  localparam logic [N*W-1:0] IMG = build_img();

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b0;
  logic       clr = 1'b0;
  logic [3:0] opc = 4'd0;
  logic [10:0] uop;

  int checks = 0;
  int fails = 0;
  int m_addr = 0;
  string tag = "R7";
  bit done = 1'b0;

  always #2 clk = ~clk;

  ucode_sequencer #(.WORD_W(W), .IMAGE(IMG)) uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .clr_i(clr), .opcode_i(opc), .uop_o(uop)
  );

  function automatic logic [10:0] exp_uop(int a);
    logic [7:0] ad;
    ad = 8'(a);
    return {ad[2:0] ^ 3'b101, ad};
  endfunction

  // behavioural reference of the address
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr = 0; tag = "R7";
    end else if (clr) begin
      m_addr = 0; tag = en ? "R4" : "R5";
    end else if (!en) begin
      tag = "R6";
    end else if (((m_addr % 5) == 0)) begin
      m_addr = int'(opc) * 16; tag = "R3";
    end else begin
      m_addr = (m_addr * 37 + 11) % 256; tag = "R2";
    end
  end

  task automatic check(string t);
    checks++;
    if (uop !== exp_uop(m_addr)) begin
      fails++;
      $display("FAIL %s (R1 uop): actual %h expected %h", t, uop, exp_uop(m_addr));
    end
  endtask

  always @(posedge clk) begin
    #1;
    if (!done) check(tag);
  end

  task automatic drive(bit e, bit c, logic [3:0] o);
    @(negedge clk);
    en = e; clr = c; opc = o;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #0.5;
    check("R7 reset");
    rst_n = 1'b1;
    // linked steps with opcode varying (R2: opcode ignored)
    drive(1, 0, 4'hF);
    for (int i = 0; i < 40; i++) drive(1, 0, 4'(i));
    // hold (R6)
    for (int i = 0; i < 10; i++) drive(0, 0, 4'(i + 3));
    // clear with and without enable (R4, R5)
    drive(1, 1, 4'h7);
    drive(1, 0, 4'h9);
    drive(1, 0, 4'h2);
    drive(0, 1, 4'h1);
    drive(0, 0, 4'h1);
    // mixed random traffic
    for (int i = 0; i < 3000; i++) begin
      int r;
      r = $urandom_range(0, 99);
      drive(r < 80, r >= 95, 4'($urandom_range(0, 15)));
    end
    // asynchronous reset mid-run (R7)
    drive(1, 0, 4'h3);
    drive(1, 0, 4'h4);
    #0.5 rst_n = 1'b0;
    #0.5;
    checks++;
    if (uop !== exp_uop(0)) begin
      fails++;
      $display("FAIL R7 async: actual %h expected %h", uop, exp_uop(0));
    end
    drive(1, 0, 4'h5);
    rst_n = 1'b1;
    for (int i = 0; i < 200; i++) drive(1, 0, 4'($urandom_range(0, 15)));
    drive(0, 0, 4'h0);
    @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #100000;
    if (!done) begin
      done = 1'b1;
      checks++;
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule